// File: doc/BRIEF.md
# Oversampled UART with Divisor Latch

A full-duplex asynchronous serial port. A byte-wide register port programs a 16-bit clock divisor, a frame format and two interrupt masks, loads transmit data and reads received data and status. A shared tick generator divides the system clock by the divisor to give a tick at 16 times the bit rate. Both the transmitter and the receiver are paced by this tick. A divisor of zero counts as 65536, so the bit rate ranges from the system clock over 16 down to the system clock over 1,048,576.

A frame is one low start bit, then 5 to 8 data bits with the LSB first, then an optional parity bit, then one or two high stop bits. A frame is therefore 7 to 12 bits long. The receiver takes its start timing from a high-to-low transition and samples every bit at the middle of its 16 ticks. It reports parity errors, framing errors and overruns in a status register. Transmit and receive each drive an interrupt line with its own mask.

Register map (addr): 0 data (a write sends, a read returns the received byte); 1 divisor upper byte; 2 divisor lower byte; 3 format; 4 interrupt masks; 5 status (read only). Addresses 6 and 7 read as zero.

Top module: `uart_core`

## Requirements
- R1: After reset, txLine is high and both interrupts are low. Divisor high reads 0x00 and divisor low reads 0x01. Format reads 0x03, mask reads 0x00 and status reads 0x00. Addresses 6 and 7 read 0x00.
- R2: Address 1 holds divisor bits 15:8 and address 2 holds bits 7:0. Both read back as written. One serial bit lasts 16 × divisor clock cycles.
- R3: A divisor of 0 acts as 65536, so one bit lasts 1,048,576 cycles.
- R4: A write to address 0 while the transmitter is idle starts a frame in the next cycle. The frame is start 0, then data LSB first, then parity if enabled, then stop bits of 1. Format bits: [1:0] = data bits − 5, [2] = parity enable, [3] = odd parity, [4] = two stop bits. The line is high whenever the transmitter is idle.
- R5: With even parity, the parity bit makes the count of ones in the data plus parity even. Odd parity makes it odd. Only the enabled data bits count.
- R6: Status bit 1 is the transmit busy flag. A write to address 0 while busy has no effect: the current frame is unchanged and no further frame follows.
- R7: Status bit 0 is set when a frame is received. A read of address 0 returns the data with the unused upper bits at zero. The read clears status bits 0, 2, 3 and 4.
- R8: A start bit that is high again at its middle (the 8th tick after detection) is discarded, and the receiver waits for a new start.
- R9: A low first stop bit sets status bit 3 (framing error).
- R10: A received parity bit that does not match the selected parity sets status bit 2.
- R11: A frame that completes while status bit 0 is still set sets status bit 4 (overrun). The newer data replaces the held byte.
- R12: Mask bit 0 enables txIrq, which is high while the transmitter is idle. Mask bit 1 enables rxIrq, which is high while status bit 0 is set.
- R13: A start is only detected on a high-to-low transition. A line held low after a frame does not begin a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| txIrq | output | 1 | Masked transmit-idle interrupt |
| rxIrq | output | 1 | Masked receive-ready interrupt |

## Verification
A wrong tick count or bit index shows on txLine within one bit period, as a bit that is shifted, stretched or cut short. It is caught by mid-bit sampling of every frame position, at two divisors and at the shortest and longest frame. A receiver state that drifts or retriggers shows within one frame as a wrong byte or as a stray status flag: valid, parity, framing or overrun. Each frame is read back right after its stop bit. A busy flag that is stuck or early shows on txIrq and as a ghost frame in the idle window that follows each frame.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_DIVHI = 3'd1;
  localparam logic [2:0] ADDR_DIVLO = 3'd2;
  localparam logic [2:0] ADDR_FMT   = 3'd3;
  localparam logic [2:0] ADDR_MASK  = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  localparam int MAX_FRAME = 12;  // start + 8 data + parity + 2 stop
  localparam int RX_BITS   = 9;   // data plus parity captured by receiver

  // strobes from control to datapath
  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       rxClear;
    logic       rxStore;
    logic [3:0] rxIdx;
    logic       rxFinish;
  } strobe_t;

  function automatic logic parityOf(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/uart_ctrl.sv
module uart_ctrl import uart_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic       tick,
  input  logic       rxBit,
  input  logic [1:0] lenCode,
  input  logic       parEn,
  input  logic       twoStop,
  output strobe_t    stb,
  output logic       txBusy
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rxState_t;

  logic [3:0] nData, frameLen, rxLen;
  assign nData    = 4'd5 + {2'b00, lenCode};
  assign frameLen = 4'd2 + nData + {3'b000, parEn} + {3'b000, twoStop};
  assign rxLen    = nData + {3'b000, parEn};

  // transmit sequencing
  logic             txBusyR;
  logic [SUB_W-1:0] txSub;
  logic [3:0]       txIdx;
  logic             txAccept, txBitEnd, txLastBit;

  assign txAccept  = wrEn && (addr == ADDR_DATA) && !txBusyR;
  assign txBitEnd  = txBusyR && tick && (txSub == SUB_LAST);
  assign txLastBit = (txIdx == frameLen - 4'd1);
  assign txBusy    = txBusyR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusyR <= 1'b0;
      txSub   <= '0;
      txIdx   <= '0;
    end else if (txAccept) begin
      txBusyR <= 1'b1;
      txSub   <= '0;
      txIdx   <= '0;
    end else if (txBusyR && tick) begin
      if (txSub == SUB_LAST) begin
        txSub <= '0;
        if (txLastBit) txBusyR <= 1'b0;
        else           txIdx   <= txIdx + 4'd1;
      end else begin
        txSub <= txSub + 1'b1;
      end
    end
  end

  // receive sequencing
  rxState_t         rxState;
  logic [SUB_W-1:0] rxSub;
  logic [3:0]       rxIdxR;
  logic             rxLast;
  logic             startSeen, rxSubEnd;

  assign startSeen = (rxState == RX_IDLE) && tick && rxLast && !rxBit;
  assign rxSubEnd  = tick && (rxSub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxIdxR  <= '0;
      rxLast  <= 1'b1;
    end else begin
      if (tick) rxLast <= rxBit;
      unique case (rxState)
        RX_IDLE: if (startSeen) begin
          rxState <= RX_START;
          rxSub   <= '0;
        end
        RX_START: if (tick) begin
          if (rxSub == SUB_MID) begin
            rxSub   <= '0;
            rxIdxR  <= '0;
            rxState <= rxBit ? RX_IDLE : RX_BITS;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
        RX_BITS: if (tick) begin
          if (rxSub == SUB_LAST) begin
            rxSub <= '0;
            if (rxIdxR == rxLen - 4'd1) rxState <= RX_STOP;
            else                        rxIdxR  <= rxIdxR + 4'd1;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (rxSub == SUB_LAST) rxState <= RX_IDLE;
          else                   rxSub   <= rxSub + 1'b1;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.txLoad   = txAccept;
    stb.txShift  = txBitEnd && !txLastBit;
    stb.rxClear  = startSeen;
    stb.rxStore  = (rxState == RX_BITS) && rxSubEnd;
    stb.rxIdx    = rxIdxR;
    stb.rxFinish = (rxState == RX_STOP) && rxSubEnd;
  end
endmodule

// File: rtl/uart_dpath.sv
module uart_dpath import uart_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  input  logic       rxLine,
  input  strobe_t    stb,
  input  logic       txBusy,
  output logic [7:0] rdData,
  output logic       txLine,
  output logic       txIrq,
  output logic       rxIrq,
  output logic       tick,
  output logic       rxBit,
  output logic [1:0] lenCode,
  output logic       parEn,
  output logic       twoStop
);
  localparam int HI_W  = DIV_W - 8;
  localparam int CNT_W = DIV_W + 1;

  // programmable registers
  logic [HI_W-1:0] divHi;
  logic [7:0]      divLo;
  logic [1:0]      lenR;
  logic            parEnR, oddR, twoR;
  logic [1:0]      maskR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divHi  <= '0;
      divLo  <= 8'd1;
      lenR   <= 2'd3;
      parEnR <= 1'b0;
      oddR   <= 1'b0;
      twoR   <= 1'b0;
      maskR  <= '0;
    end else if (wrEn) begin
      unique case (addr)
        ADDR_DIVHI: divHi <= wrData[HI_W-1:0];
        ADDR_DIVLO: divLo <= wrData;
        ADDR_FMT: begin
          lenR   <= wrData[1:0];
          parEnR <= wrData[2];
          oddR   <= wrData[3];
          twoR   <= wrData[4];
        end
        ADDR_MASK: maskR <= wrData[1:0];
        default: ;
      endcase
    end
  end

  assign lenCode = lenR;
  assign parEn   = parEnR;
  assign twoStop = twoR;

  // oversampling tick generator, divisor zero counts as 2**DIV_W
  logic [DIV_W-1:0] divisor;
  logic [CNT_W-1:0] limit, baudCnt;
  assign divisor = {divHi, divLo};
  assign limit   = (divisor == '0) ? (CNT_W'(1) << DIV_W) : {1'b0, divisor};
  assign tick    = (baudCnt >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) baudCnt <= '0;
    else       baudCnt <= tick ? '0 : baudCnt + CNT_W'(1);
  end

  // receive line synchronizer
  logic rxMeta, rxSyncR;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSyncR <= 1'b1;
    end else begin
      rxMeta  <= rxLine;
      rxSyncR <= rxMeta;
    end
  end
  assign rxBit = rxSyncR;

  // transmit shift register
  logic [7:0]           dataMask;
  logic                 txPar;
  logic [MAX_FRAME-1:0] frameVec, txSh;
  int                   nDataInt;

  assign dataMask = 8'hFF >> (2'd3 - lenR);
  assign nDataInt = int'(lenR) + 5;
  assign txPar    = parityOf(wrData & dataMask, oddR);

  always_comb begin
    frameVec    = '1;
    frameVec[0] = 1'b0;
    for (int i = 1; i < MAX_FRAME; i++) begin
      if (i <= nDataInt && i <= 8) frameVec[i] = wrData[(i - 1) % 8];
      else if (parEnR && i == nDataInt + 1) frameVec[i] = txPar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            txSh <= '1;
    else if (stb.txLoad)  txSh <= frameVec;
    else if (stb.txShift) txSh <= {1'b1, txSh[MAX_FRAME-1:1]};
  end
  assign txLine = txSh[0];

  // receive capture and status
  logic [RX_BITS-1:0] rxReg;
  logic [7:0]         rxData, rxMasked;
  logic               rxValid, pErr, fErr, ovr;
  logic               rxParBit, rxParBad, rdRx;

  assign rxMasked = rxReg[7:0] & dataMask;
  always_comb begin
    unique case (lenR)
      2'd0: rxParBit = rxReg[5];
      2'd1: rxParBit = rxReg[6];
      2'd2: rxParBit = rxReg[7];
      default: rxParBit = rxReg[8];
    endcase
  end
  assign rxParBad = parEnR && (rxParBit != parityOf(rxMasked, oddR));
  assign rdRx     = rdEn && (addr == ADDR_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg   <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      pErr    <= 1'b0;
      fErr    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (stb.rxClear) rxReg <= '0;
      else if (stb.rxStore) begin
        for (int i = 0; i < RX_BITS; i++)
          if (stb.rxIdx == 4'(i)) rxReg[i] <= rxBit;
      end
      if (stb.rxFinish) begin
        rxData  <= rxMasked;
        rxValid <= 1'b1;
        pErr    <= rxParBad;
        fErr    <= !rxBit;
        ovr     <= (ovr || rxValid) && !rdRx;
      end else if (rdRx) begin
        rxValid <= 1'b0;
        pErr    <= 1'b0;
        fErr    <= 1'b0;
        ovr     <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_DATA:  rdData = rxData;
      ADDR_DIVHI: rdData = 8'(divHi);
      ADDR_DIVLO: rdData = divLo;
      ADDR_FMT:   rdData = {3'b000, twoR, oddR, parEnR, lenR};
      ADDR_MASK:  rdData = {6'b0, maskR};
      ADDR_STAT:  rdData = {3'b000, ovr, fErr, pErr, txBusy, rxValid};
      default:    rdData = '0;
    endcase
  end

  assign txIrq = maskR[0] && !txBusy;
  assign rxIrq = maskR[1] && rxValid;
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxLine,
  output logic       txLine,
  output logic       txIrq,
  output logic       rxIrq
);
  strobe_t    stb;
  logic       tick, rxBit, parEn, twoStop, txBusy;
  logic [1:0] lenCode;

  uart_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .tick(tick),
    .rxBit(rxBit), .lenCode(lenCode), .parEn(parEn), .twoStop(twoStop),
    .stb(stb), .txBusy(txBusy)
  );

  uart_dpath #(.DIV_W(DIV_W)) dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rxLine(rxLine), .stb(stb), .txBusy(txBusy),
    .rdData(rdData), .txLine(txLine), .txIrq(txIrq), .rxIrq(rxIrq),
    .tick(tick), .rxBit(rxBit), .lenCode(lenCode), .parEn(parEn),
    .twoStop(twoStop)
  );
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk import uart_pkg::*; (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic       txLine,
  input logic       rxIrq,
  input logic       tick,
  input logic       txBusy,
  input strobe_t    stb
);
  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && wrEn && addr == ADDR_DATA) |=> (txBusy && !txLine));

  assert_busy_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && wrEn && addr == ADDR_DATA && !stb.txShift) |=> $stable(txLine));

  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txShift || stb.rxClear || stb.rxStore || stb.rxFinish) |-> tick);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_DATA && !stb.rxFinish) |=> !rxIrq);

  assert_rx_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rxClear, stb.rxStore, stb.rxFinish}));
endmodule

bind uart_core uart_core_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .txLine(txLine), .rxIrq(rxIrq), .tick(tick), .txBusy(txBusy), .stb(stb)
);

// File: tb/uart_core_tb_top.sv
`timescale 1ns/100ps
module uart_core_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rxLine = 1'b1;
  logic       txLine, txIrq, rxIrq;
  int         errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  uart_core dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxLine(rxLine), .txLine(txLine),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setup(input int div, input logic [7:0] fmt);
    regWrite(3'd1, 8'((div >> 8) & 255));
    regWrite(3'd2, 8'(div & 255));
    regWrite(3'd3, fmt);
  endtask

  // frame per R4/R5: start, data LSB first, parity, stops
  function automatic int buildFrame(input logic [7:0] d, input logic [7:0] fmt,
                                    output logic [11:0] v);
    int nd;
    logic [7:0] m;
    nd = 5 + int'(fmt[1:0]);
    m  = 8'hFF >> (8 - nd);
    v  = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[i + 1] = d[i];
    if (fmt[2]) v[nd + 1] = (^(d & m)) ^ fmt[3];
    return 2 + nd + int'(fmt[2]) + int'(fmt[4]);
  endfunction

  task automatic testReset();
    logic [7:0] v;
    chk("R1 txLine", txLine, 1);
    chk("R1 txIrq", txIrq, 0);
    chk("R1 rxIrq", rxIrq, 0);
    regRead(3'd1, v); chk("R1 divisor high", v, 8'h00);
    regRead(3'd2, v); chk("R1 divisor low", v, 8'h01);
    regRead(3'd3, v); chk("R1 format", v, 8'h03);
    regRead(3'd4, v); chk("R1 mask", v, 8'h00);
    regRead(3'd5, v); chk("R1 status", v, 8'h00);
    regRead(3'd6, v); chk("R1 unused address", v, 8'h00);
  endtask

  task automatic testDivRegs();
    logic [7:0] v;
    regWrite(3'd1, 8'hAB); regWrite(3'd2, 8'hCD);
    regRead(3'd1, v); chk("R2 divisor high readback", v, 8'hAB);
    regRead(3'd2, v); chk("R2 divisor low readback", v, 8'hCD);
  endtask

  task automatic testTx(input string tag, input int div, input logic [7:0] fmt,
                        input logic [7:0] d, input bit busyWrite);
    logic [11:0] v;
    logic [7:0]  st;
    int len, k, target, bad;
    setup(div, fmt);
    regWrite(3'd4, 8'h01);
    len = buildFrame(d, fmt, v);
    @(negedge clk); addr = 3'd0; wrData = d; wrEn = 1'b1;
    k = 0;
    for (int i = 0; i < len; i++) begin
      target = (16 * i + 8) * div + 1;
      while (k < target) begin
        @(negedge clk); k++;
        wrEn = busyWrite && (k == 32 * div);
        if (wrEn) wrData = ~d;
      end
      chk({tag, " R4 R5 tx bit"}, txLine, v[i]);
    end
    chk({tag, " R12 txIrq low while busy"}, txIrq, 0);
    target = 16 * len * div + 2 * div + 2;
    while (k < target) begin @(negedge clk); k++; end
    chk({tag, " R4 line idle high"}, txLine, 1);
    chk({tag, " R12 txIrq when idle"}, txIrq, 1);
    bad = 0;
    repeat (16 * len * div) begin
      @(negedge clk);
      if (txLine !== 1'b1) bad++;
    end
    chk({tag, " R6 no extra frame"}, bad, 0);
    regRead(3'd5, st);
    chk({tag, " R6 busy bit clear"}, st[1], 0);
    regWrite(3'd4, 8'h00);
  endtask

  task automatic rxSend(input int div, input logic [11:0] v, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rxLine = v[i];
      repeat (16 * div - 1) @(negedge clk);
    end
  endtask

  task automatic rxExpect(input string tag, input logic [7:0] expSt,
                          input logic [7:0] expData);
    logic [7:0] v;
    repeat (4) @(negedge clk);
    regRead(3'd5, v); chk({tag, " status"}, v, expSt);
    regRead(3'd0, v); chk({tag, " R7 data"}, v, expData);
    regRead(3'd5, v); chk({tag, " R7 status after read"}, v, 8'h00);
  endtask

  task automatic testRxBasic();
    logic [11:0] v;
    int len;
    setup(1, 8'h03);
    regWrite(3'd4, 8'h02);
    len = buildFrame(8'hA5, 8'h03, v);
    rxSend(1, v, len);
    repeat (4) @(negedge clk);
    chk("R12 rxIrq on valid", rxIrq, 1);
    rxExpect("R7 8N1", 8'h01, 8'hA5);
    chk("R12 rxIrq after read", rxIrq, 0);
    regWrite(3'd4, 8'h00);
    setup(3, 8'h14);
    len = buildFrame(8'hFB, 8'h14, v);
    rxSend(3, v, len);
    rxExpect("R7 R5 5-bit even parity", 8'h01, 8'h1B);
  endtask

  task automatic testRxParity();
    logic [11:0] v;
    int len;
    setup(1, 8'h0E);
    len = buildFrame(8'h4D, 8'h0E, v);
    rxSend(1, v, len);
    rxExpect("R10 good odd parity", 8'h01, 8'h4D);
    v[8] = ~v[8];
    rxSend(1, v, len);
    rxExpect("R10 bad parity", 8'h05, 8'h4D);
  endtask

  task automatic testRxFraming();
    logic [11:0] v;
    logic [7:0]  st;
    int len;
    setup(1, 8'h03);
    len = buildFrame(8'h3C, 8'h03, v);
    v[9] = 1'b0;
    rxSend(1, v, len);
    repeat (100) @(negedge clk);
    rxExpect("R9 framing error", 8'h09, 8'h3C);
    repeat (300) @(negedge clk);
    regRead(3'd5, st);
    chk("R13 held low line starts no frame", st, 8'h00);
    @(negedge clk); rxLine = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic testRxOverrun();
    logic [11:0] v;
    int len;
    setup(1, 8'h03);
    len = buildFrame(8'h11, 8'h03, v);
    rxSend(1, v, len);
    len = buildFrame(8'h22, 8'h03, v);
    rxSend(1, v, len);
    rxExpect("R11 overrun", 8'h11, 8'h22);
  endtask

  task automatic testFalseStart();
    logic [11:0] v;
    logic [7:0]  st;
    int len;
    setup(1, 8'h03);
    @(negedge clk); rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rxLine = 1'b1;
    repeat (300) @(negedge clk);
    regRead(3'd5, st);
    chk("R8 glitch discarded", st, 8'h00);
    len = buildFrame(8'h5A, 8'h03, v);
    rxSend(1, v, len);
    rxExpect("R8 receiver recovers", 8'h01, 8'h5A);
  endtask

  task automatic testDivZero();
    int highs;
    setup(0, 8'h03);
    @(negedge clk); addr = 3'd0; wrData = 8'hFF; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    highs = 0;
    for (int i = 0; i < 120; i++) begin
      repeat (1000) @(negedge clk);
      if (txLine !== 1'b0) highs++;
    end
    chk("R3 divisor zero start bit still low after 120k cycles", highs, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivRegs();
    testTx("T12bit", 1, 8'h1F, 8'h96, 1'b1);
    testTx("T7bit", 1, 8'h00, 8'hF3, 1'b0);
    testTx("Tdiv3", 3, 8'h06, 8'h5C, 1'b0);
    testRxBasic();
    testRxParity();
    testRxFraming();
    testRxOverrun();
    testFalseStart();
    testDivZero();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule